// File: doc/BRIEF.md
# Recirculating Shuffle-Exchange Router

This block routes a batch of up to N = 2^n tagged packets to their destination ports. It has only one stage of hardware: a perfect-shuffle link feeding a column of N/2 two-by-two exchange switches. The packets are sent around that stage once per clock for n passes. On each pass every slot first moves to the position given by rotating its address one bit to the left. Then each switch either passes its pair of packets straight through or swaps them. The switch decides by looking at one bit of a packet's destination tag, taken most significant bit first.

A client presents N words, each with a valid bit and an n-bit destination tag, and pulses `load` while the block is idle. The port registers show the batch after every pass. `done` pulses on the cycle in which the final arrangement becomes visible. Two live packets in one switch may need the same output. In that case the packet on the upper (even) input keeps its route, and the other is marked blocked and travels on without routing. A blocked packet does not reach its destination and is reported as blocked.

Top module: `shx_router`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every port reads `port_valid`=0 and `port_blocked`=0, and `busy`=0 and `done`=0.
- R2: `load` sampled high while `busy`=0 starts a batch. After that edge, port i holds input i's data, tag and valid bit with blocked=0, and `busy`=1.
- R3: On pass k (k=0 first), the packet at position p moves to position rotl(p) by one bit. The switch on the pair (2j, 2j+1) then makes the low bit of a live packet's position equal to bit n-1-k of its tag. Positions and tags are unsigned, and bit 0 is the least significant.
- R4: When both packets at a switch are live and want the same low bit, the even-position (upper) packet receives its choice. The odd-position packet takes the other output and gets blocked=1.
- R5: A blocked packet keeps blocked=1 until the next load. It never affects a switch setting: it takes whichever output the other packet leaves.
- R6: Exactly n passes follow a load, one per clock. `busy` falls and `done` is high for exactly one cycle on the edge of the last pass.
- R7: After the last pass, every valid packet that is not blocked sits at the port equal to its tag.
- R8: `load` while `busy`=1 is ignored, and the running batch is unaffected.
- R9: Slots loaded with valid=0 remain invalid and are never marked blocked. The number of valid ports stays constant during a batch.
- R10: While idle with no load, the port outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| load | input | 1 | start a batch (taken only when idle) |
| in_valid | input | N | valid bit per input |
| in_dest | input | N*ADDR_W | destination tag per input, input i at bits [i*ADDR_W +: ADDR_W] |
| in_data | input | N*DATA_W | payload per input, input i at bits [i*DATA_W +: DATA_W] |
| port_valid | output | N | valid bit at each position |
| port_blocked | output | N | blocked flag at each position |
| port_dest | output | N*ADDR_W | tag carried at each position |
| port_data | output | N*DATA_W | payload at each position |
| busy | output | 1 | batch in progress |
| done | output | 1 | one-cycle pulse after the last pass |

## Verification
The assertions take for granted that `load` is the only stimulus that can change the slots and that no reset occurs in the middle of a batch. The valid-count and blocked-count properties depend on both. The stimulus meets these conditions: reset is applied only at the start and in one final directed step, and every check that compares pass by pass runs on a batch with no reset. One extra `load` carrying different data is driven into a running batch to show that the batch continues unchanged. Tags and valid masks come from a small vector table. The table covers conflict-free permutations, total collisions, identical tags and sparse valid masks, so both switch settings and the priority rule are exercised.

// File: rtl/shx_pkg.sv
package shx_pkg;

  typedef enum logic {
    CTRL_IDLE = 1'b0,
    CTRL_RUN  = 1'b1
  } ctrl_state_t;

  // Perfect-shuffle target: one-bit left rotation of a w-bit position.
  function automatic int shuffle_pos(input int p, input int w);
    int mask;
    mask = (1 << w) - 1;
    return ((p << 1) | (p >> (w - 1))) & mask;
  endfunction

endpackage

// File: rtl/shx_shuffle.sv
module shx_shuffle #(
  parameter int ADDR_W = 3,
  parameter int PW     = 13
) (
  input  logic [(1<<ADDR_W)-1:0][PW-1:0] slot_in,
  output logic [(1<<ADDR_W)-1:0][PW-1:0] slot_out
);
  localparam int N = 1 << ADDR_W;

  for (genvar i = 0; i < N; i++) begin : g_link
    localparam int TGT = shx_pkg::shuffle_pos(i, ADDR_W);
    assign slot_out[TGT] = slot_in[i];
  end

endmodule

// File: rtl/shx_exchange.sv
module shx_exchange #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0]        sel_mask,
  input  logic [DATA_W+ADDR_W+1:0] upper,
  input  logic [DATA_W+ADDR_W+1:0] lower,
  output logic [DATA_W+ADDR_W+1:0] out_even,
  output logic [DATA_W+ADDR_W+1:0] out_odd
);
  localparam int PW    = DATA_W + ADDR_W + 2;
  localparam int V_BIT = PW - 1;
  localparam int B_BIT = PW - 2;

  logic u_live, l_live, u_want, l_want, swap, l_blk_next;
  logic [PW-1:0] lower_upd;

  always_comb begin
    u_live = upper[V_BIT] & ~upper[B_BIT];
    l_live = lower[V_BIT] & ~lower[B_BIT];
    u_want = |(upper[DATA_W +: ADDR_W] & sel_mask);
    l_want = |(lower[DATA_W +: ADDR_W] & sel_mask);
    // Upper input has priority; a lower input only steers when upper is idle.
    if (u_live)      swap = u_want;
    else if (l_live) swap = ~l_want;
    else             swap = 1'b0;
    l_blk_next = lower[B_BIT] | (u_live & l_live & (u_want == l_want));
    lower_upd  = {lower[V_BIT], l_blk_next, lower[B_BIT-1:0]};
    out_even   = swap ? lower_upd : upper;
    out_odd    = swap ? upper : lower_upd;
  end

endmodule

// File: rtl/shx_pass_ctrl.sv
module shx_pass_ctrl #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  output logic              accept,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] sel_mask
);
  import shx_pkg::*;

  localparam int              CW   = $clog2(ADDR_W + 1);
  localparam logic [CW-1:0]   LAST = CW'(ADDR_W - 1);
  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(1) << (ADDR_W - 1);

  ctrl_state_t     state_q;
  logic [CW-1:0]   pass_q;

  assign busy     = (state_q == CTRL_RUN);
  assign accept   = load && (state_q == CTRL_IDLE);
  assign sel_mask = TOP >> pass_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CTRL_IDLE;
      pass_q  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        state_q <= CTRL_RUN;
        pass_q  <= '0;
      end else if (state_q == CTRL_RUN) begin
        if (pass_q == LAST) begin
          state_q <= CTRL_IDLE;
          pass_q  <= '0;
          done    <= 1'b1;
        end else begin
          pass_q <= pass_q + 1'b1;
        end
      end
    end
  end

  // R6: passes advance by one per clock until the last
  assert_pass_step_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && pass_q != LAST) |=> (busy && pass_q == $past(pass_q) + 1'b1));

  // R6: done is a single-cycle pulse
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: done only while idle
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R6: the last pass always ends the batch
  assert_last_ends_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && pass_q == LAST) |=> (!busy && done));

endmodule

// File: rtl/shx_router.sv
module shx_router #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           load,
  input  logic [(1<<ADDR_W)-1:0]         in_valid,
  input  logic [(1<<ADDR_W)*ADDR_W-1:0]  in_dest,
  input  logic [(1<<ADDR_W)*DATA_W-1:0]  in_data,
  output logic [(1<<ADDR_W)-1:0]         port_valid,
  output logic [(1<<ADDR_W)-1:0]         port_blocked,
  output logic [(1<<ADDR_W)*ADDR_W-1:0]  port_dest,
  output logic [(1<<ADDR_W)*DATA_W-1:0]  port_data,
  output logic                           busy,
  output logic                           done
);
  localparam int N     = 1 << ADDR_W;
  localparam int PW    = DATA_W + ADDR_W + 2;
  localparam int V_BIT = PW - 1;
  localparam int B_BIT = PW - 2;

  logic [N-1:0][PW-1:0] slot_q, shuf_w, exch_w, load_w;
  logic [ADDR_W-1:0]    sel_mask;
  logic                 accept;

  shx_pass_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .load(load), .accept(accept),
    .busy(busy), .done(done), .sel_mask(sel_mask)
  );

  shx_shuffle #(.ADDR_W(ADDR_W), .PW(PW)) u_shuffle (
    .slot_in(slot_q), .slot_out(shuf_w)
  );

  for (genvar j = 0; j < N/2; j++) begin : g_switch
    shx_exchange #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sw (
      .sel_mask(sel_mask),
      .upper(shuf_w[2*j]), .lower(shuf_w[2*j+1]),
      .out_even(exch_w[2*j]), .out_odd(exch_w[2*j+1])
    );
  end

  for (genvar i = 0; i < N; i++) begin : g_port
    assign load_w[i] = {in_valid[i], 1'b0,
                        in_dest[i*ADDR_W +: ADDR_W],
                        in_data[i*DATA_W +: DATA_W]};
    assign port_valid[i]                 = slot_q[i][V_BIT];
    assign port_blocked[i]               = slot_q[i][B_BIT];
    assign port_dest[i*ADDR_W +: ADDR_W] = slot_q[i][DATA_W +: ADDR_W];
    assign port_data[i*DATA_W +: DATA_W] = slot_q[i][DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)         slot_q <= '0;
    else if (accept) slot_q <= load_w;
    else if (busy)   slot_q <= exch_w;
  end

  // R9: passes neither create nor drop valid packets
  assert_valid_count_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !$past(rst)) |=> ($countones(port_valid) == $past($countones(port_valid))));

  // R5: the number of blocked packets never drops during a batch
  assert_blocked_mono_R5: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($countones(port_blocked) >= $past($countones(port_blocked))));

  // R9: a blocked slot is always a valid slot
  assert_blocked_valid_R9: assert property (@(posedge clk) disable iff (rst)
    ((port_blocked & ~port_valid) == '0));

  // R10: idle with no load keeps the ports unchanged
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !load) |=> ($stable(port_data) && $stable(port_valid) && $stable(port_blocked)));

  // R8: a load during a batch does not restart the pass sequence
  assert_load_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && load) |=> ($countones(port_valid) == $past($countones(port_valid))));

endmodule

// File: tb/shx_router_test.sv
`timescale 1ns/1ps
module shx_router_test;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  typedef struct packed {
    logic [N*AW-1:0] dst;
    logic [N-1:0]    vld;
  } vec_t;

  // Tags: input i at bits [3i+:3]
  localparam vec_t VECS [6] = '{
    '{dst: 24'hFAC688, vld: 8'hFF},  // identity
    '{dst: 24'h053977, vld: 8'hFF},  // complement
    '{dst: 24'h1F58D1, vld: 8'hFF},  // rotate by one
    '{dst: 24'h000000, vld: 8'hFF},  // all collide on 0
    '{dst: 24'hB6DB6D, vld: 8'h5A},  // sparse, same tag
    '{dst: 24'h053977, vld: 8'h81}   // two packets only
  };

  logic clk = 0, rst = 1, load = 0;
  logic [N-1:0]    in_valid = '0;
  logic [N*AW-1:0] in_dest  = '0;
  logic [N*DW-1:0] in_data  = '0;
  logic [N-1:0]    port_valid, port_blocked;
  logic [N*AW-1:0] port_dest;
  logic [N*DW-1:0] port_data;
  logic            busy, done;

  int total = 0, bad = 0;
  bit finished = 0;

  int m_pos [N], m_dst [N], m_dat [N];
  bit m_val [N], m_blk [N];

  always #2.5 clk = ~clk;

  shx_router #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .load(load), .in_valid(in_valid),
    .in_dest(in_dest), .in_data(in_data), .port_valid(port_valid),
    .port_blocked(port_blocked), .port_dest(port_dest),
    .port_data(port_data), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Independent per-packet model of one pass.
  task automatic model_pass(input int k);
    int occ [N];
    for (int i = 0; i < N; i++) occ[((m_pos[i] << 1) | (m_pos[i] >> (AW-1))) & (N-1)] = i;
    for (int j = 0; j < N/2; j++) begin
      int u, l;
      bit ua, la, uw, lw, sw;
      u  = occ[2*j]; l = occ[2*j+1];
      ua = m_val[u] && !m_blk[u];
      la = m_val[l] && !m_blk[l];
      uw = m_dst[u][AW-1-k];
      lw = m_dst[l][AW-1-k];
      sw = ua ? uw : (la ? !lw : 1'b0);
      if (ua && la && uw == lw) m_blk[l] = 1;
      m_pos[u] = 2*j + int'(sw);
      m_pos[l] = 2*j + int'(!sw);
    end
  endtask

  task automatic compare(input string req);
    for (int i = 0; i < N; i++) begin
      int p;
      p = m_pos[i];
      chk(port_valid[p] == m_val[i], {req, " valid"}, port_valid[p], m_val[i]);
      chk(port_blocked[p] == m_blk[i], {req, " blocked"}, port_blocked[p], m_blk[i]);
      if (m_val[i]) begin
        chk(port_data[p*DW +: DW] == DW'(m_dat[i]), {req, " data"}, port_data[p*DW +: DW], m_dat[i]);
        chk(port_dest[p*AW +: AW] == AW'(m_dst[i]), {req, " dest"}, port_dest[p*AW +: AW], m_dst[i]);
      end
    end
  endtask

  // Runs one batch; if disturb is set a second load arrives mid-batch.
  task automatic run_batch(input vec_t v, input int seed, input bit disturb);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      m_pos[i] = i; m_blk[i] = 0; m_val[i] = v.vld[i];
      m_dst[i] = int'(v.dst[i*AW +: AW]);
      m_dat[i] = ((seed * 16) + i) & 8'hFF;
      in_data[i*DW +: DW] = DW'(m_dat[i]);
    end
    in_valid = v.vld; in_dest = v.dst; load = 1;
    @(negedge clk);
    load = 0;
    chk(busy == 1, "R2 busy after load", busy, 1);
    compare("R2 load capture");
    for (int k = 0; k < AW; k++) begin
      if (disturb && k == 1) begin
        in_valid = ~v.vld; in_dest = ~v.dst; in_data = ~in_data; load = 1;
      end
      @(negedge clk);
      load = 0;
      model_pass(k);
      compare((k == AW-1) ? "R7 final" : "R3/R4/R5 pass");
      chk(done == (k == AW-1), "R6 done timing", done, int'(k == AW-1));
      chk(busy == (k != AW-1), "R6 busy timing", busy, int'(k != AW-1));
    end
    if (disturb) compare("R8 load during batch ignored");
    @(negedge clk);
    chk(done == 0, "R6 done single pulse", done, 0);
    compare("R10 hold while idle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(port_valid == '0 && port_blocked == '0, "R1 reset ports", port_valid, 0);
    chk(busy == 0 && done == 0, "R1 reset flags", {busy, done}, 0);
    rst = 0;
    @(negedge clk);
    chk(busy == 0 && done == 0 && port_valid == '0, "R1 after reset", busy, 0);

    for (int t = 0; t < 6; t++) run_batch(VECS[t], t + 1, 0);

    // R4: all tags 0 -> packet from input 0 routes, the rest are blocked
    run_batch(VECS[3], 9, 0);
    chk(port_valid[0] && !port_blocked[0] && port_data[DW-1:0] == 8'h90,
        "R4 upper wins total collision", port_data[DW-1:0], 8'h90);
    chk($countones(port_blocked) == 7, "R4 seven blocked", $countones(port_blocked), 7);

    // R9: sparse mask keeps invalid slots clean
    run_batch(VECS[5], 10, 0);
    chk($countones(port_valid) == 2 && (port_blocked & ~port_valid) == '0,
        "R9 invalid stay invalid", $countones(port_valid), 2);

    // R8: load during batch ignored
    run_batch(VECS[0], 11, 1);

    // R1: reset from a loaded state
    rst = 1;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(port_valid == '0 && busy == 0 && done == 0, "R1 reset after use", port_valid, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule